// File: doc/BRIEF.md
# Memory Power-State Sequencer

This block follows the platform's sleep signals and decides which memory supply rails are on. It keeps one of five power states: G3 (mechanical off), S5OFF (soft-off with the dual 5 V rail down), S5ON (soft-off with the dual 5 V rail up), S0 (full power) and S3 (suspend to RAM). From these states it drives enable lines for the dual 5 V rail and for the memory rails. A mode pin picks one of two rail sets. In mode A the memory rails are str1 and a bus-termination rail. In mode B they are str1, str2 and str3.

A counter stands in for the soft-start capacitor. When the block moves up from S5OFF to S5ON, or from S5ON to S0, the counter starts at zero and rises by one each cycle. The new state is taken only after the counter has reached its terminal count. The rails that are powering up are enabled while the ramp runs. In mode B, str3 starts ahead of str1 and str2 by a set number of ramp steps, which spreads out the inrush charging. A separate open-drain output pulls the power-good line low whenever a fault flag is raised.

Top module: `mem_pwr_seq`

## Requirements
- R1: `pwr_state` reports the state as G3=0, S5OFF=1, S5ON=2, S0=3, S3=4, and no other value ever appears. While `rst_n` is low the block is in G3 with every rail enable low and `ss_level`=0.
- R2: In G3, the first clock edge that samples `supply_ok`=1 moves the block to S5OFF.
- R3: While `supply_ok` is 0, every rail enable is low in that same cycle. The next clock edge puts the block in G3 from any state and clears the ramp.
- R4: In S5OFF, the advance condition is `dual_en_n`=0, or `slp3_n`=1 and `slp5_n`=1. While it holds, `ss_level` rises by one per edge starting from 0. The edge after `ss_level` reaches 2^RAMP_W-1 enters S5ON and returns `ss_level` to 0. If the condition drops during the ramp, `ss_level` returns to 0 and the state stays S5OFF. `rail5_en` is high while `ss_level` is non-zero in S5OFF.
- R5: In S5ON with `slp3_n`=1 and `slp5_n`=1, the same ramp runs and ends by entering S0. Otherwise `dual_en_n`=1 returns the block to S5OFF on the next edge.
- R6: In S0, `slp5_n`=0 enters soft-off on the next edge: S5ON if `dual_en_n`=0, else S5OFF. `slp3_n`=0 with `slp5_n`=1 enters S3.
- R7: In S3, `slp5_n`=0 enters soft-off as in R6. `slp3_n`=1, `slp5_n`=1 and `pwr_good_in`=1 return the block to S0 on the next edge with no ramp. Without `pwr_good_in` the block stays in S3.
- R8: `rail5_en` is high in S5ON, S0 and S3. The memory rails are on in S0 and S3. With `mode_a`=1 those rails are `str1_en` and `bt_en`, and `str2_en` and `str3_en` stay low. With `mode_a`=0 they are `str1_en`, `str2_en` and `str3_en`, and `bt_en` stays low. In G3 every enable is low.
- R9: During the S5ON-to-S0 ramp in mode B, `str3_en` turns on once `ss_level`>=1, and `str1_en` and `str2_en` turn on once `ss_level`>STR3_LEAD (default 32). In mode A, `str1_en` and `bt_en` both turn on once `ss_level`>=1.
- R10: `pg_pull_low` is high in the same cycle that `oc_fault` or `uv_fault` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Main 5 V input above its good threshold |
| slp3_n | input | 1 | Suspend-to-RAM request, active low |
| slp5_n | input | 1 | Soft-off request, active low |
| dual_en_n | input | 1 | Keep the dual 5 V rail up in soft-off, active low |
| pwr_good_in | input | 1 | External system supplies good |
| mode_a | input | 1 | 1 selects mode A (str1 + termination), 0 selects mode B |
| oc_fault | input | 1 | Overcurrent flag |
| uv_fault | input | 1 | Undervoltage flag |
| pwr_state | output | 3 | Current power state code |
| ss_level | output | RAMP_W | Soft-start ramp level |
| rail5_en | output | 1 | Dual 5 V rail enable |
| str1_en | output | 1 | str1 rail enable |
| str2_en | output | 1 | str2 rail enable (mode B) |
| str3_en | output | 1 | str3 rail enable (mode B) |
| bt_en | output | 1 | Bus-termination rail enable (mode A) |
| pg_pull_low | output | 1 | Pull the power-good line low |

## Verification
The assertions check on every cycle that the state code is legal and that a lost supply lands in G3. They also check that the ramp only counts up by one or clears, and that each ramped transition is entered straight from the terminal count. Other per-cycle checks cover S3 holding without power-good, the mode-dependent rail exclusions, and str1 never running ahead of str3 in mode B.

Only the bench scenarios can show the exact ramp lengths, the str3 lead of STR3_LEAD steps, and a ramp abort that leaves the state unchanged. The same holds for the choice between S5ON and S5OFF on soft-off, the return from S5ON to S5OFF, and the complete walk through every state.

// File: rtl/mps_pkg.sv
package mps_pkg;

    typedef enum logic [2:0] {
        PS_G3    = 3'd0,
        PS_S5OFF = 3'd1,
        PS_S5ON  = 3'd2,
        PS_S0    = 3'd3,
        PS_S3    = 3'd4
    } pwr_state_e;

endpackage

// File: rtl/mps_ramp.sv
module mps_ramp #(
    parameter int RAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [RAMP_W-1:0] level,
    output logic              done
);
    localparam logic [RAMP_W-1:0] RAMP_MAX = '1;

    logic [RAMP_W-1:0] level_q;

    // Counts up while run is held; clears on terminal count or drop of run.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (!run || level_q == RAMP_MAX) begin
            level_q <= '0;
        end else begin
            level_q <= level_q + 1'b1;
        end
    end

    assign level = level_q;
    assign done  = (level_q == RAMP_MAX);

endmodule

// File: rtl/mps_fsm.sv
module mps_fsm
    import mps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       slp3_n,
    input  logic       slp5_n,
    input  logic       dual_en_n,
    input  logic       pwr_good_in,
    input  logic       ramp_done,
    output pwr_state_e state,
    output logic       ramp_run
);
    pwr_state_e state_q;
    pwr_state_e state_d;

    logic awake;
    logic soft_off_req;
    pwr_state_e soft_off_tgt;

    assign awake        = slp3_n && slp5_n;
    assign soft_off_req = !slp5_n;
    assign soft_off_tgt = dual_en_n ? PS_S5OFF : PS_S5ON;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_G3;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and ramp request
    always_comb begin
        state_d  = state_q;
        ramp_run = 1'b0;
        if (!supply_ok) begin
            state_d = PS_G3;
        end else begin
            unique case (state_q)
                PS_G3: begin
                    state_d = PS_S5OFF;
                end
                PS_S5OFF: begin
                    if (!dual_en_n || awake) begin
                        ramp_run = 1'b1;
                        if (ramp_done) begin
                            state_d = PS_S5ON;
                        end
                    end
                end
                PS_S5ON: begin
                    if (awake) begin
                        ramp_run = 1'b1;
                        if (ramp_done) begin
                            state_d = PS_S0;
                        end
                    end else if (dual_en_n) begin
                        state_d = PS_S5OFF;
                    end
                end
                PS_S0: begin
                    if (soft_off_req) begin
                        state_d = soft_off_tgt;
                    end else if (!slp3_n) begin
                        state_d = PS_S3;
                    end
                end
                PS_S3: begin
                    if (soft_off_req) begin
                        state_d = soft_off_tgt;
                    end else if (awake && pwr_good_in) begin
                        state_d = PS_S0;
                    end
                end
                default: begin
                    state_d = PS_G3;
                end
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/mps_rail_out.sv
module mps_rail_out
    import mps_pkg::*;
#(
    parameter int RAMP_W    = 8,
    parameter int STR3_LEAD = 32
) (
    input  pwr_state_e        state,
    input  logic [RAMP_W-1:0] level,
    input  logic              supply_ok,
    input  logic              mode_a,
    output logic              rail5_en,
    output logic              str1_en,
    output logic              str2_en,
    output logic              str3_en,
    output logic              bt_en
);
    localparam logic [RAMP_W-1:0] LEAD_CNT = RAMP_W'(STR3_LEAD);

    logic ramping;
    logic mem_on;
    logic early_on;
    logic late_on;
    logic dual_on;

    assign ramping = (level != '0);

    // Output decode
    always_comb begin
        dual_on = 1'b0;
        mem_on  = 1'b0;
        unique case (state)
            PS_G3:    begin dual_on = 1'b0;    mem_on = 1'b0; end
            PS_S5OFF: begin dual_on = ramping; mem_on = 1'b0; end
            PS_S5ON:  begin dual_on = 1'b1;    mem_on = 1'b0; end
            PS_S0:    begin dual_on = 1'b1;    mem_on = 1'b1; end
            PS_S3:    begin dual_on = 1'b1;    mem_on = 1'b1; end
            default:  begin dual_on = 1'b0;    mem_on = 1'b0; end
        endcase
    end

    assign early_on = mem_on || (state == PS_S5ON && ramping);

    generate
        if (STR3_LEAD == 0) begin : g_no_lead
            assign late_on = early_on;
        end else begin : g_lead
            assign late_on = mem_on || (state == PS_S5ON && level > LEAD_CNT);
        end
    endgenerate

    assign rail5_en = supply_ok && dual_on;
    assign str1_en  = supply_ok && (mode_a ? early_on : late_on);
    assign str2_en  = supply_ok && !mode_a && late_on;
    assign str3_en  = supply_ok && !mode_a && early_on;
    assign bt_en    = supply_ok && mode_a && early_on;

endmodule

// File: rtl/mem_pwr_seq.sv
module mem_pwr_seq
    import mps_pkg::*;
#(
    parameter int RAMP_W    = 8,
    parameter int STR3_LEAD = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              slp3_n,
    input  logic              slp5_n,
    input  logic              dual_en_n,
    input  logic              pwr_good_in,
    input  logic              mode_a,
    input  logic              oc_fault,
    input  logic              uv_fault,
    output logic [2:0]        pwr_state,
    output logic [RAMP_W-1:0] ss_level,
    output logic              rail5_en,
    output logic              str1_en,
    output logic              str2_en,
    output logic              str3_en,
    output logic              bt_en,
    output logic              pg_pull_low
);
    pwr_state_e        state;
    logic              ramp_run;
    logic              ramp_done;
    logic [RAMP_W-1:0] level;

    mps_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .slp3_n      (slp3_n),
        .slp5_n      (slp5_n),
        .dual_en_n   (dual_en_n),
        .pwr_good_in (pwr_good_in),
        .ramp_done   (ramp_done),
        .state       (state),
        .ramp_run    (ramp_run)
    );

    mps_ramp #(.RAMP_W(RAMP_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ramp_run),
        .level (level),
        .done  (ramp_done)
    );

    mps_rail_out #(.RAMP_W(RAMP_W), .STR3_LEAD(STR3_LEAD)) u_rails (
        .state     (state),
        .level     (level),
        .supply_ok (supply_ok),
        .mode_a    (mode_a),
        .rail5_en  (rail5_en),
        .str1_en   (str1_en),
        .str2_en   (str2_en),
        .str3_en   (str3_en),
        .bt_en     (bt_en)
    );

    assign pwr_state   = state;
    assign ss_level    = level;
    assign pg_pull_low = oc_fault || uv_fault;

endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
    parameter int RAMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              pwr_good_in,
    input logic              mode_a,
    input logic [2:0]        pwr_state,
    input logic [RAMP_W-1:0] ss_level,
    input logic              rail5_en,
    input logic              str1_en,
    input logic              str2_en,
    input logic              str3_en,
    input logic              bt_en
);
    localparam logic [RAMP_W-1:0] RAMP_MAX = '1;

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state <= 3'd4); // R1

    AST_SUPPLY_LOSS_G3: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (pwr_state == 3'd0 && ss_level == '0)); // R3

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_level != '0) |=> (ss_level == '0 || ss_level == $past(ss_level) + 1'b1)); // R4

    AST_S5ON_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd2 && $past(pwr_state) == 3'd1) |-> ($past(ss_level) == RAMP_MAX)); // R4

    AST_S0_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd3 && $past(pwr_state) == 3'd2) |-> ($past(ss_level) == RAMP_MAX)); // R5

    AST_S3_HOLD_NO_PWOK: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd4 && supply_ok && !pwr_good_in) |=> (pwr_state != 3'd3)); // R7

    AST_G3_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd0) |-> !(rail5_en || str1_en || str2_en || str3_en || bt_en)); // R8

    AST_MODE_A_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_a |-> (!str2_en && !str3_en)); // R8

    AST_MODE_B_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_a |-> !bt_en); // R8

    AST_STR3_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_a && str1_en) |-> str3_en); // R9

endmodule

bind mem_pwr_seq mps_checker #(.RAMP_W(RAMP_W)) u_mps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .pwr_good_in (pwr_good_in),
    .mode_a      (mode_a),
    .pwr_state   (pwr_state),
    .ss_level    (ss_level),
    .rail5_en    (rail5_en),
    .str1_en     (str1_en),
    .str2_en     (str2_en),
    .str3_en     (str3_en),
    .bt_en       (bt_en)
);

// File: tb/test_mem_pwr_seq.sv
module test_mem_pwr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RW   = 8;
    localparam int LEAD = 32;
    localparam int M    = (1 << RW) - 1;

    logic clk = 1'b0;
    logic rst_n, supply_ok, slp3_n, slp5_n, dual_en_n, pwr_good_in, mode_a, oc_fault, uv_fault;
    logic [2:0]    pwr_state;
    logic [RW-1:0] ss_level;
    logic rail5_en, str1_en, str2_en, str3_en, bt_en, pg_pull_low;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_pwr_seq #(.RAMP_W(RW), .STR3_LEAD(LEAD)) i_mem_pwr_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .slp3_n(slp3_n), .slp5_n(slp5_n),
        .dual_en_n(dual_en_n), .pwr_good_in(pwr_good_in), .mode_a(mode_a),
        .oc_fault(oc_fault), .uv_fault(uv_fault), .pwr_state(pwr_state), .ss_level(ss_level),
        .rail5_en(rail5_en), .str1_en(str1_en), .str2_en(str2_en), .str3_en(str3_en),
        .bt_en(bt_en), .pg_pull_low(pg_pull_low)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 0; supply_ok = 0; slp3_n = 0; slp5_n = 0; dual_en_n = 1;
        pwr_good_in = 0; mode_a = 0; oc_fault = 0; uv_fault = 0;
        tick(3);
        chk("R1", "state in reset", pwr_state, 0);
        chk("R1", "rail5 in reset", rail5_en, 0);
        chk("R1", "str1 in reset", str1_en, 0);
        chk("R1", "ramp in reset", ss_level, 0);
        rst_n = 1;
        tick(2);
        chk("R2", "G3 held without supply", pwr_state, 0);
    endtask

    task automatic t_power_up();
        supply_ok = 1;
        tick(1);
        chk("R2", "G3 to S5OFF", pwr_state, 1);
        tick(3);
        chk("R4", "S5OFF idle state", pwr_state, 1);
        chk("R4", "S5OFF idle ramp", ss_level, 0);
        chk("R4", "S5OFF idle rail5", rail5_en, 0);
    endtask

    task automatic t_ramp_abort();
        dual_en_n = 0;
        tick(5);
        chk("R4", "ramp level after 5", ss_level, 5);
        chk("R4", "rail5 during ramp", rail5_en, 1);
        chk("R4", "state during ramp", pwr_state, 1);
        dual_en_n = 1;
        tick(1);
        chk("R4", "ramp cleared on abort", ss_level, 0);
        chk("R4", "state after abort", pwr_state, 1);
        chk("R4", "rail5 after abort", rail5_en, 0);
    endtask

    task automatic t_ramp_s5on();
        dual_en_n = 0;
        tick(M);
        chk("R4", "ramp at terminal", ss_level, M);
        chk("R4", "still S5OFF at terminal", pwr_state, 1);
        tick(1);
        chk("R4", "entered S5ON", pwr_state, 2);
        chk("R4", "ramp reset on entry", ss_level, 0);
        chk("R8", "rail5 in S5ON", rail5_en, 1);
        chk("R8", "str1 off in S5ON", str1_en, 0);
    endtask

    task automatic t_s5on_exit();
        dual_en_n = 1;
        tick(1);
        chk("R5", "S5ON back to S5OFF", pwr_state, 1);
        dual_en_n = 0;
        tick(M + 1);
        chk("R4", "second ramp to S5ON", pwr_state, 2);
    endtask

    task automatic t_ramp_s0_mode_b();
        mode_a = 0; slp3_n = 1; slp5_n = 1;
        tick(1);
        chk("R9", "ramp started", ss_level, 1);
        chk("R9", "str3 early", str3_en, 1);
        chk("R9", "str1 held back", str1_en, 0);
        chk("R9", "str2 held back", str2_en, 0);
        tick(LEAD - 1);
        chk("R9", "str1 still off at lead", str1_en, 0);
        tick(1);
        chk("R9", "str1 on after lead", str1_en, 1);
        chk("R9", "str2 on after lead", str2_en, 1);
        tick(M - LEAD - 1);
        chk("R5", "S5ON at ramp terminal", pwr_state, 2);
        tick(1);
        chk("R5", "entered S0", pwr_state, 3);
        chk("R8", "mode B str1", str1_en, 1);
        chk("R8", "mode B str2", str2_en, 1);
        chk("R8", "mode B str3", str3_en, 1);
        chk("R8", "mode B bt off", bt_en, 0);
        chk("R8", "rail5 in S0", rail5_en, 1);
    endtask

    task automatic t_s3_cycle();
        slp3_n = 0;
        tick(1);
        chk("R6", "S0 to S3", pwr_state, 4);
        chk("R8", "str3 kept in S3", str3_en, 1);
        pwr_good_in = 0; slp3_n = 1;
        tick(3);
        chk("R7", "S3 waits for power good", pwr_state, 4);
        pwr_good_in = 1;
        tick(1);
        chk("R7", "S3 to S0 with power good", pwr_state, 3);
    endtask

    task automatic t_s0_softoff();
        slp5_n = 0;
        tick(1);
        chk("R6", "S0 soft-off to S5ON", pwr_state, 2);
        chk("R6", "str1 off in soft-off", str1_en, 0);
        chk("R6", "rail5 kept in S5ON", rail5_en, 1);
        dual_en_n = 1;
        tick(1);
        chk("R5", "S5ON to S5OFF", pwr_state, 1);
    endtask

    task automatic t_mode_a();
        mode_a = 1; dual_en_n = 0; slp3_n = 1; slp5_n = 1;
        tick(M + 1);
        chk("R4", "mode A reached S5ON", pwr_state, 2);
        tick(1);
        chk("R9", "mode A str1 at ramp start", str1_en, 1);
        chk("R9", "mode A bt at ramp start", bt_en, 1);
        chk("R8", "mode A str3 off", str3_en, 0);
        tick(M);
        chk("R5", "mode A in S0", pwr_state, 3);
        chk("R8", "mode A str1 in S0", str1_en, 1);
        chk("R8", "mode A bt in S0", bt_en, 1);
        chk("R8", "mode A str2 off", str2_en, 0);
    endtask

    task automatic t_s3_to_off();
        slp3_n = 0;
        tick(1);
        chk("R6", "mode A S0 to S3", pwr_state, 4);
        slp5_n = 0; dual_en_n = 1;
        tick(1);
        chk("R7", "S3 soft-off to S5OFF", pwr_state, 1);
        chk("R7", "rail5 off in S5OFF", rail5_en, 0);
    endtask

    task automatic t_supply_loss();
        dual_en_n = 0;
        tick(M + 1);
        chk("R4", "S5ON before supply loss", pwr_state, 2);
        supply_ok = 0;
        #1;
        chk("R3", "rail5 drops at once", rail5_en, 0);
        tick(1);
        chk("R3", "G3 after supply loss", pwr_state, 0);
        chk("R3", "ramp clear after loss", ss_level, 0);
        supply_ok = 1;
        tick(1);
        chk("R2", "S5OFF after supply returns", pwr_state, 1);
    endtask

    task automatic t_fault();
        oc_fault = 1; #1;
        chk("R10", "pull low on overcurrent", pg_pull_low, 1);
        oc_fault = 0; uv_fault = 1; #1;
        chk("R10", "pull low on undervoltage", pg_pull_low, 1);
        uv_fault = 0; #1;
        chk("R10", "released without fault", pg_pull_low, 0);
    endtask

    initial begin
        t_reset();
        t_power_up();
        t_ramp_abort();
        t_ramp_s5on();
        t_s5on_exit();
        t_ramp_s0_mode_b();
        t_s3_cycle();
        t_s0_softoff();
        t_mode_a();
        t_s3_to_off();
        t_supply_loss();
        t_fault();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule